// File: doc/BRIEF.md
# Early-Terminating Shift-Add Multiplier

This block multiplies two 16-bit unsigned operands in several clock cycles and returns a 32-bit product as a low word and a high word. A caller raises `start_i` for one cycle with the multiplicand and the multiplier. The block raises `busy_o` while it works and pulses `done_o` for one cycle when the product is ready. The product words then stay on the outputs until the next accepted start.

Before it begins, the block extends the multiplier with a 1 bit placed below its least significant bit. This extra bit acts as an end marker. In the first phase the block only shifts, one bit per cycle, and so removes the multiplier's leading zeros without any adds. The second phase begins at the leading 1. That first 1 loads the multiplicand straight into the product. Each later step doubles the 32-bit product and adds the multiplicand when the current multiplier bit is 1. The block stops when the end marker reaches the top of the working register. A zero multiplier skips both phases and finishes after a single cycle.

The controller has four states. `ST_IDLE` waits for a start. It moves to `ST_DONE` on a zero multiplier, to `ST_ACCUM` when the multiplier's top bit is already 1, and to `ST_SCAN` otherwise. `ST_SCAN` shifts and moves to `ST_ACCUM` once the bit now at the top is 1. `ST_ACCUM` performs one product step per cycle and moves to `ST_DONE` when only the marker is left. `ST_DONE` pulses `done_o` and returns to `ST_IDLE`. A cycle counter, `cycles_o`, makes the number of scan and accumulate cycles visible.

Top module: `seq_mul_early`

## Requirements
- R1: A start with a multiplier of 0 gives `done_o` in the first cycle after the start edge, with both product words equal to 0 and `busy_o` never high.
- R2: For a nonzero multiplier, the product outputs at `done_o` equal the unsigned product of the operands: bits 15:0 on `prod_lo_o` and bits 31:16 on `prod_hi_o`.
- R3: For a nonzero multiplier, `busy_o` is high for exactly 16 cycles after the start edge, and `done_o` appears in the 17th cycle after it.
- R4: `cycles_o` is cleared by an accepted start and counts scan and accumulate cycles. At `done_o` it equals the number of leading zeros plus the number of remaining multiplier bits, which is 16 for a nonzero multiplier, and 0 for a zero multiplier. It stays below 16 while `busy_o` is high.
- R5: `done_o` is high for exactly one cycle per operation and is never high together with `busy_o`.
- R6: `start_i` is ignored while `busy_o` or `done_o` is high; the product and the timing of the running operation are unchanged.
- R7: After `done_o`, both product words and `cycles_o` hold their values until the next accepted start.
- R8: After reset, `busy_o` and `done_o` are low, and both product words and `cycles_o` are 0.
- R9: A multiplicand of 0 with a nonzero multiplier still takes the full 16-cycle path and gives a product of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation; accepted only in the idle state |
| mcand_i | input | 16 | Multiplicand, sampled at an accepted start |
| mplier_i | input | 16 | Multiplier, sampled at an accepted start |
| busy_o | output | 1 | High during the scan and accumulate phases |
| done_o | output | 1 | One-cycle pulse when the product is valid |
| prod_lo_o | output | 16 | Product bits 15:0 |
| prod_hi_o | output | 16 | Product bits 31:16 |
| cycles_o | output | 5 | Scan plus accumulate cycles of the current or last operation |

## Verification
The bench tests a multiplier of 1, which has the longest scan, and a multiplier whose top bit is set, which has no scan at all. A controller that misses the leading 1 would either drop that bit's multiplicand or add it twice, and the high product word would be wrong. A multiplier of 0 must finish in one cycle. A design that let it fall into the scan loop would never see the top bit and would hang. The bench also covers a zero multiplicand, a full 0xFFFF by 0xFFFF product that fills every high-word bit, and a second start raised in the middle of an operation. A design that accepted that second start would report a different product or a different latency.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_ACCUM = 2'd2,
        ST_DONE  = 2'd3
    } mul_state_e;

    // Datapath commands issued by the controller for one cycle.
    typedef struct packed {
        logic load;   // capture operands, arm end marker, clear product
        logic scan;   // shift working register only
        logic accum;  // shift working register and update product
        logic count;  // advance the cycle counter
    } mul_ctl_t;

endpackage

// File: rtl/seq_mul_ctrl.sv
module seq_mul_ctrl
    import seq_mul_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     mplier_zero_i,
    input  logic     mplier_top_i,
    input  logic     next_top_i,
    input  logic     last_step_i,
    output mul_ctl_t ctl_o,
    output logic     busy_o,
    output logic     done_o
);

    mul_state_e state_q;
    mul_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (mplier_zero_i) begin
                        state_d = ST_DONE;
                    end else if (mplier_top_i) begin
                        state_d = ST_ACCUM;
                    end else begin
                        state_d = ST_SCAN;
                    end
                end
            end
            ST_SCAN: begin
                if (next_top_i) begin
                    state_d = ST_ACCUM;
                end
            end
            ST_ACCUM: begin
                if (last_step_i) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        ctl_o  = '0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ctl_o.load = start_i;
            end
            ST_SCAN: begin
                ctl_o.scan  = 1'b1;
                ctl_o.count = 1'b1;
                busy_o      = 1'b1;
            end
            ST_ACCUM: begin
                ctl_o.accum = 1'b1;
                ctl_o.count = 1'b1;
                busy_o      = 1'b1;
            end
            ST_DONE: begin
                done_o = 1'b1;
            end
            default: begin
                ctl_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/seq_mul_datapath.sv
module seq_mul_datapath
    import seq_mul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  mul_ctl_t       ctl_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic           next_top_o,
    output logic           last_step_o,
    output logic [2*W-1:0] prod_o
);

    localparam int WORK_W = W + 1;
    localparam int PROD_W = 2 * W;

    logic [WORK_W-1:0] work_q;
    logic [W-1:0]      mcand_q;
    logic [PROD_W-1:0] prod_q;
    logic              first_q;

    logic [WORK_W-1:0] work_shl;
    logic [PROD_W-1:0] addend;
    logic [PROD_W-1:0] prod_step;

    assign work_shl = {work_q[WORK_W-2:0], 1'b0};

    // Bit that will sit at the top after this cycle's shift.
    assign next_top_o = work_q[WORK_W-2];

    // After this shift only the end marker remains, now at the top.
    assign last_step_o = (work_shl == {1'b1, {(WORK_W-1){1'b0}}});

    assign addend    = work_q[WORK_W-1] ? {{W{1'b0}}, mcand_q} : '0;
    assign prod_step = {prod_q[PROD_W-2:0], 1'b0} + addend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q  <= '0;
            mcand_q <= '0;
            prod_q  <= '0;
            first_q <= 1'b0;
        end else if (ctl_i.load) begin
            work_q  <= {mplier_i, 1'b1};
            mcand_q <= mcand_i;
            prod_q  <= '0;
            first_q <= 1'b1;
        end else if (ctl_i.scan) begin
            work_q <= work_shl;
        end else if (ctl_i.accum) begin
            work_q  <= work_shl;
            first_q <= 1'b0;
            if (first_q) begin
                prod_q <= {{W{1'b0}}, mcand_q};
            end else begin
                prod_q <= prod_step;
            end
        end
    end

    assign prod_o = prod_q;

endmodule

// File: rtl/seq_mul_cycle_cnt.sv
module seq_mul_cycle_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/seq_mul_early.sv
module seq_mul_early
    import seq_mul_pkg::*;
#(
    parameter int W     = 16,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [W-1:0]     mcand_i,
    input  logic [W-1:0]     mplier_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [W-1:0]     prod_lo_o,
    output logic [W-1:0]     prod_hi_o,
    output logic [CNT_W-1:0] cycles_o
);

    mul_ctl_t       ctl;
    logic           next_top;
    logic           last_step;
    logic           mplier_zero;
    logic           mplier_top;
    logic [2*W-1:0] prod;

    assign mplier_zero = (mplier_i == '0);
    assign mplier_top  = mplier_i[W-1];

    seq_mul_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .mplier_zero_i (mplier_zero),
        .mplier_top_i  (mplier_top),
        .next_top_i    (next_top),
        .last_step_i   (last_step),
        .ctl_o         (ctl),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    seq_mul_datapath #(.W(W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_i       (ctl),
        .mcand_i     (mcand_i),
        .mplier_i    (mplier_i),
        .next_top_o  (next_top),
        .last_step_o (last_step),
        .prod_o      (prod)
    );

    seq_mul_cycle_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ctl.load),
        .inc_i (ctl.count),
        .cnt_o (cycles_o)
    );

    assign prod_lo_o = prod[W-1:0];
    assign prod_hi_o = prod[2*W-1:W];

endmodule

// File: rtl/seq_mul_early_chk.sv
module seq_mul_early_chk #(
    parameter int W     = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [W-1:0]     mplier_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [W-1:0]     prod_lo_o,
    input logic [W-1:0]     prod_hi_o,
    input logic [CNT_W-1:0] cycles_o
);

    logic idle;
    assign idle = !busy_o && !done_o;

    p_zero_fast_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start_i && mplier_i == '0) |=> (done_o && prod_lo_o == '0 && prod_hi_o == '0));

    p_busy_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start_i && mplier_i != '0) |=> (busy_o && cycles_o == '0));

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cycles_o < CNT_W'(W)));

    p_done_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cycles_o == CNT_W'(W) || cycles_o == '0));

    p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> ($stable(prod_lo_o) && $stable(prod_hi_o) && $stable(cycles_o)));

endmodule

bind seq_mul_early seq_mul_early_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .prod_lo_o (prod_lo_o),
    .prod_hi_o (prod_hi_o),
    .cycles_o  (cycles_o)
);

// File: tb/test_seq_mul_early.sv
`timescale 1ns/1ps
module test_seq_mul_early;

    localparam int W     = 16;
    localparam int CNT_W = $clog2(W + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [W-1:0]     mcand_i = '0;
    logic [W-1:0]     mplier_i = '0;
    logic             busy_o;
    logic             done_o;
    logic [W-1:0]     prod_lo_o;
    logic [W-1:0]     prod_hi_o;
    logic [CNT_W-1:0] cycles_o;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    seq_mul_early #(.W(W)) i_seq_mul_early (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .prod_lo_o (prod_lo_o),
        .prod_hi_o (prod_hi_o),
        .cycles_o  (cycles_o)
    );

    function automatic logic [2*W-1:0] ref_prod(logic [W-1:0] a, logic [W-1:0] b);
        return {{W{1'b0}}, a} * {{W{1'b0}}, b};
    endfunction

    function automatic int ref_latency(logic [W-1:0] b);
        return (b == '0) ? 1 : W + 1;
    endfunction

    function automatic int ref_cycles(logic [W-1:0] b);
        return (b == '0) ? 0 : W;
    endfunction

    function automatic int ref_busy(logic [W-1:0] b);
        return (b == '0) ? 0 : W;
    endfunction

    task automatic check(string req, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Run one operation; poke_at > 0 raises start for one cycle at that
    // cycle of the running operation with different operands.
    task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, int poke_at, string tag);
        int n;
        int busy_seen;
        int dones;
        logic [2*W-1:0] exp_p;
        exp_p = ref_prod(a, b);
        @(negedge clk);
        mcand_i  = a;
        mplier_i = b;
        start_i  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i   = 1'b0;
        mcand_i   = ~a;
        mplier_i  = ~b;
        n         = 1;
        busy_seen = 0;
        while (!done_o && n < 100) begin
            if (busy_o) busy_seen++;
            if (n == poke_at) start_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            n++;
        end
        check({tag, " R2 product"}, longint'({prod_hi_o, prod_lo_o}), longint'(exp_p));
        check({tag, " R3 latency"}, n, ref_latency(b));
        check({tag, " R3 busy cycles"}, busy_seen, ref_busy(b));
        check({tag, " R4 cycle count"}, cycles_o, ref_cycles(b));
        // R5: done is a single-cycle pulse; R7: values hold afterwards
        dones = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (done_o) dones++;
        end
        check({tag, " R5 done pulse"}, dones, 0);
        check({tag, " R7 hold"}, longint'({cycles_o, prod_hi_o, prod_lo_o}),
              longint'({CNT_W'(ref_cycles(b)), exp_p}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] a;
        logic [W-1:0] b;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check("R8 busy", busy_o, 0);
        check("R8 done", done_o, 0);
        check("R8 product", longint'({prod_hi_o, prod_lo_o}), 0);
        check("R8 cycles", cycles_o, 0);

        run_op(16'h1234, 16'h0000, 0, "R1 zero mplier");
        run_op(16'h0000, 16'h0000, 0, "R1 both zero");
        run_op(16'hBEEF, 16'h0001, 0, "R2 mplier one");
        run_op(16'h0003, 16'h8000, 0, "R2 top bit");
        run_op(16'hFFFF, 16'hFFFF, 0, "R2 full");
        run_op(16'h0001, 16'hA5A5, 0, "R2 unit mcand");
        run_op(16'h0000, 16'h7FFF, 0, "R9 zero mcand");
        run_op(16'h00FF, 16'h0100, 0, "R2 single one");
        run_op(16'h4321, 16'h00F0, 5, "R6 start in scan");
        run_op(16'h9876, 16'hC001, 12, "R6 start in accum");
        run_op(16'h1357, 16'h0000, 0, "R6 after poke");

        for (int i = 0; i < 40; i++) begin
            logic [31:0] mask;
            mask = (32'h1 << ($urandom % 17)) - 1;
            a = W'($urandom);
            b = W'($urandom & mask);
            run_op(a, b, 0, "R2 random");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule